// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds sixteen general registers and a status word whose low five bits select the processor mode. Some modes get private copies of the upper registers. One fast-interrupt mode has private R8 to R14. Four other privileged modes have private R13 and R14 only. Every other mode value sees the shared set. Each privileged mode also owns a saved-status slot. A restore request copies that slot back into the status word.

Two combinational read ports and one write port address registers by their architectural number. The mode in the status word decides which physical copy each number reaches. A mode change takes effect at the clock edge that accepts it. Reads in the next cycle already see the new window. No data moves between registers when the mode changes, because the physical copies are addressed directly.

Top module: `bank_regfile`

## Requirements
- R1: After reset every register reads zero in every mode, the status word equals the RESET_STATUS parameter (default 0x000000D3, which is mode 0x13), and the error flag is low.
- R2: With mode bits 0x11 (fast interrupt), register numbers 8 to 14 reach private copies. Writes there do not disturb the copies seen in any other mode, and writes elsewhere do not disturb them.
- R3: With mode bits 0x12, 0x13, 0x17 or 0x1B, register numbers 13 and 14 reach a private pair per mode. Numbers 8 to 12 reach the shared copies.
- R4: Any other mode value reaches the shared copies of 8 to 14. Numbers 0 to 7 and 15 are the same physical registers in every mode.
- R5: A mode request replaces status bits [4:0] with the requested mode at the next edge and keeps the other bits. A request for the current mode leaves the mapping unchanged. Without a mode or restore request the status word holds its value.
- R6: A register write and a mode request in the same cycle store the write in the view of the mode in force before the edge.
- R7: Both read ports are combinational and independent. A write shows up on the ports in the cycle after its edge.
- R8: A saved-status write stores into the slot of the current mode. In a mode with no slot it changes no slot.
- R9: A restore request in a mode that has a slot loads that slot into the whole status word at the next edge. The mapping follows the new mode bits, and the error flag stays low.
- R10: A restore request in a mode with no slot leaves the status word unchanged and drives the error flag high for the one following cycle. Otherwise the flag is low.
- R11: A restore request and a mode request in the same cycle act as the restore alone. The mode request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 4 | Read port A register number |
| rdDataA | output | DATA_W | Read port A data |
| rdAddrB | input | 4 | Read port B register number |
| rdDataB | output | DATA_W | Read port B data |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register write number |
| wrData | input | DATA_W | Register write data |
| modeChg | input | 1 | Mode change request |
| modeNew | input | 5 | Requested mode |
| spsrWr | input | 1 | Saved-status write enable |
| spsrData | input | DATA_W | Saved-status write data |
| restoreReq | input | 1 | Restore status from the current saved slot |
| statusWord | output | DATA_W | Current status word, mode in [4:0] |
| restoreErr | output | 1 | Restore attempted with no saved slot |

## Verification
A wrong mapping never appears as a lost write in the current mode. It appears when the bench leaves a mode and comes back, because a register written in one window then reads back from another. The bench therefore reads both ports on every cycle against a model that swaps copies in and out. Corruption of a banked copy shows at the first read of that number after the next return to its mode. A stale or misdirected saved-status slot shows as a wrong status word one cycle after the next restore in that mode.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;

  localparam int NUM_BANKS = 6;
  localparam int NUM_SLOTS = NUM_BANKS - 1;

  typedef struct packed {
    logic        regWe;
    logic [3:0]  regAddr;
    bank_e       bank;
    logic        spsrWe;
  } ctrl_strobe_t;

  function automatic bank_e decodeMode(input logic [4:0] m);
    case (m)
      MODE_FIQ: decodeMode = BK_FIQ;
      MODE_IRQ: decodeMode = BK_IRQ;
      MODE_SVC: decodeMode = BK_SVC;
      MODE_ABT: decodeMode = BK_ABT;
      MODE_UND: decodeMode = BK_UND;
      default:  decodeMode = BK_USR;
    endcase
  endfunction

endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_STATUS = 'hD3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic              modeChg,
  input  logic [4:0]        modeNew,
  input  logic              spsrWr,
  input  logic              restoreReq,
  input  logic [DATA_W-1:0] spsrCur,
  output ctrl_strobe_t      strobe,
  output logic [DATA_W-1:0] statusWord,
  output logic              restoreErr
);

  bank_e curBank;
  logic  hasSlot;

  assign curBank = decodeMode(statusWord[4:0]);
  assign hasSlot = (curBank != BK_USR);

  always_comb begin
    strobe.regWe   = wrEn;
    strobe.regAddr = wrAddr;
    strobe.bank    = curBank;
    strobe.spsrWe  = spsrWr && hasSlot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusWord <= RESET_STATUS;
      restoreErr <= 1'b0;
    end else if (restoreReq) begin
      restoreErr <= !hasSlot;
      if (hasSlot) begin
        statusWord <= spsrCur;
      end
    end else begin
      restoreErr <= 1'b0;
      if (modeChg) begin
        statusWord[4:0] <= modeNew;
      end
    end
  end

endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] spsrData,
  input  logic [3:0]        rdAddrA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] spsrCur
);

  localparam int LO_REGS  = 8;
  localparam int HI_REGS  = 5;
  localparam int HI_SETS  = 2;
  localparam int NUM_RD   = 2;

  logic [DATA_W-1:0] commonLo [LO_REGS];
  logic [DATA_W-1:0] pcReg;
  logic [DATA_W-1:0] hiBank   [HI_SETS][HI_REGS];
  logic [DATA_W-1:0] spLr     [NUM_BANKS][2];
  logic [DATA_W-1:0] spsrBank [NUM_SLOTS];

  logic [3:0]        rdAddr [NUM_RD];
  logic [DATA_W-1:0] rdData [NUM_RD];

  logic       hiSel;
  logic [2:0] slotIdx;

  assign hiSel   = (strobe.bank == BK_FIQ);
  assign slotIdx = 3'(strobe.bank) - 3'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LO_REGS; i++) commonLo[i] <= '0;
      pcReg <= '0;
      for (int s = 0; s < HI_SETS; s++)
        for (int i = 0; i < HI_REGS; i++) hiBank[s][i] <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        spLr[b][0] <= '0;
        spLr[b][1] <= '0;
      end
      for (int b = 0; b < NUM_SLOTS; b++) spsrBank[b] <= '0;
    end else begin
      if (strobe.regWe) begin
        if (!strobe.regAddr[3]) begin
          commonLo[strobe.regAddr[2:0]] <= wrData;
        end else if (strobe.regAddr == 4'd15) begin
          pcReg <= wrData;
        end else if (strobe.regAddr >= 4'd13) begin
          spLr[strobe.bank][strobe.regAddr == 4'd14] <= wrData;
        end else begin
          hiBank[hiSel][strobe.regAddr[2:0]] <= wrData;
        end
      end
      if (strobe.spsrWe) begin
        spsrBank[slotIdx] <= spsrData;
      end
    end
  end

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      if (!rdAddr[p][3]) begin
        rdData[p] = commonLo[rdAddr[p][2:0]];
      end else if (rdAddr[p] == 4'd15) begin
        rdData[p] = pcReg;
      end else if (rdAddr[p] >= 4'd13) begin
        rdData[p] = spLr[strobe.bank][rdAddr[p] == 4'd14];
      end else begin
        rdData[p] = hiBank[hiSel][rdAddr[p][2:0]];
      end
    end
  end

  always_comb begin
    spsrCur = '0;
    if (strobe.bank != BK_USR) spsrCur = spsrBank[slotIdx];
  end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_STATUS = 'hD3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              modeChg,
  input  logic [4:0]        modeNew,
  input  logic              spsrWr,
  input  logic [DATA_W-1:0] spsrData,
  input  logic              restoreReq,
  output logic [DATA_W-1:0] statusWord,
  output logic              restoreErr
);

  ctrl_strobe_t      strobe;
  logic [DATA_W-1:0] spsrCur;

  bank_ctrl #(.DATA_W(DATA_W), .RESET_STATUS(RESET_STATUS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .modeChg    (modeChg),
    .modeNew    (modeNew),
    .spsrWr     (spsrWr),
    .restoreReq (restoreReq),
    .spsrCur    (spsrCur),
    .strobe     (strobe),
    .statusWord (statusWord),
    .restoreErr (restoreErr)
  );

  bank_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .spsrData (spsrData),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .rdDataA  (rdDataA),
    .rdDataB  (rdDataB),
    .spsrCur  (spsrCur)
  );

endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [3:0]        rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [3:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              modeChg,
  input logic [4:0]        modeNew,
  input logic              spsrWr,
  input logic [DATA_W-1:0] spsrData,
  input logic              restoreReq,
  input logic [DATA_W-1:0] statusWord,
  input logic              restoreErr
);

  logic slotMode;
  assign slotMode = (decodeMode(statusWord[4:0]) != BK_USR);

  AST_BAD_RESTORE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    restoreReq && !slotMode |=> restoreErr && statusWord == $past(statusWord)); // R10

  AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !restoreReq |=> !restoreErr); // R10

  AST_GOOD_RESTORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    restoreReq && slotMode |=> !restoreErr); // R9

  AST_MODE_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    modeChg && !restoreReq |=> statusWord[4:0] == $past(modeNew)
      && statusWord[DATA_W-1:5] == $past(statusWord[DATA_W-1:5])); // R5

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !modeChg && !restoreReq |=> $stable(statusWord)); // R5

  AST_RESTORE_OVER_MODE: assert property (@(posedge clk) disable iff (!rstN)
    restoreReq && !slotMode && modeChg |=> $stable(statusWord)); // R11

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    rdAddrA == rdAddrB |-> rdDataA == rdDataB); // R7

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !modeChg && !restoreReq |=>
      (rdAddrA != $past(wrAddr)) || (rdDataA == $past(wrData))); // R7

endmodule

bind bank_regfile bank_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_bank_regfile.sv
`timescale 1ns/1ps
module sim_bank_regfile;

  localparam int DW = 32;
  localparam logic [DW-1:0] RST_STAT = 32'h0000_00D3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [DW-1:0] rdDataA, rdDataB, wrData = '0, spsrData = '0, statusWord;
  logic          wrEn = 1'b0, modeChg = 1'b0, spsrWr = 1'b0, restoreReq = 1'b0;
  logic [4:0]    modeNew = '0;
  logic          restoreErr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  doneRun = 1'b0;

  always #5 clk = ~clk;

  bank_regfile #(.DATA_W(DW), .RESET_STATUS(RST_STAT)) u0 (.*);

  // Reference model: visible window plus swapped-out copies
  logic [DW-1:0] mVis  [16];
  logic [DW-1:0] mFiq  [7];
  logic [DW-1:0] mPair [6][2];
  logic [DW-1:0] mSpsr [6];
  logic [DW-1:0] mStat;
  logic          mErr;

  function automatic int modeClass(input logic [4:0] m);
    case (m)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic swapClass(input int c);
    logic [DW-1:0] t;
    if (c == 1) begin
      for (int i = 0; i < 7; i++) begin
        t = mVis[8+i]; mVis[8+i] = mFiq[i]; mFiq[i] = t;
      end
    end else if (c >= 2) begin
      t = mVis[13]; mVis[13] = mPair[c][0]; mPair[c][0] = t;
      t = mVis[14]; mVis[14] = mPair[c][1]; mPair[c][1] = t;
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mVis[i] = '0;
    for (int i = 0; i < 7; i++) mFiq[i] = '0;
    for (int c = 0; c < 6; c++) begin
      mPair[c][0] = '0; mPair[c][1] = '0; mSpsr[c] = '0;
    end
    mStat = RST_STAT;
    mErr  = 1'b0;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // One cycle: drive after negedge, compare, then advance model at posedge
  task automatic step(input logic we, input logic [3:0] wa, input logic [DW-1:0] wd,
                      input logic mc, input logic [4:0] mn,
                      input logic sw, input logic [DW-1:0] sd, input logic rr,
                      input logic [3:0] ra, input logic [3:0] rb, input string tag);
    int            cOld;
    logic [DW-1:0] nStat;
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd; modeChg = mc; modeNew = mn;
    spsrWr = sw; spsrData = sd; restoreReq = rr; rdAddrA = ra; rdAddrB = rb;
    #1;
    check(tag, $sformatf("rdA[%0d]", ra), rdDataA, mVis[ra]);
    check(tag, $sformatf("rdB[%0d]", rb), rdDataB, mVis[rb]);
    check(tag, "status", statusWord, mStat);
    check(tag, "restoreErr", {31'b0, restoreErr}, {31'b0, mErr});
    @(posedge clk);
    cOld  = modeClass(mStat[4:0]);
    nStat = mStat;
    mErr  = 1'b0;
    if (rr) begin
      if (cOld != 0) nStat = mSpsr[cOld];
      else mErr = 1'b1;
    end else if (mc) begin
      nStat[4:0] = mn;
    end
    if (we) mVis[wa] = wd;
    if (sw && cOld != 0) mSpsr[cOld] = sd;
    if (nStat[4:0] != mStat[4:0]) begin
      swapClass(cOld);
      swapClass(modeClass(nStat[4:0]));
    end
    mStat = nStat;
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d, input string tag);
    step(1'b1, a, d, 1'b0, 5'h0, 1'b0, '0, 1'b0, a, a, tag);
  endtask

  task automatic setMode(input logic [4:0] m, input string tag);
    step(1'b0, 4'd0, '0, 1'b1, m, 1'b0, '0, 1'b0, 4'd13, 4'd14, tag);
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] b, input string tag);
    step(1'b0, 4'd0, '0, 1'b0, 5'h0, 1'b0, '0, 1'b0, a, b, tag);
  endtask

  function automatic logic [4:0] pickMode(input int k);
    case (k % 8)
      0: return 5'h10;
      1: return 5'h11;
      2: return 5'h12;
      3: return 5'h13;
      4: return 5'h17;
      5: return 5'h1B;
      6: return 5'h1F;
      default: return 5'($urandom);
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!doneRun) begin
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state through both ports
    for (int i = 0; i < 16; i += 2) rd(4'(i), 4'(i + 1), "R1");
    setMode(5'h11, "R1");
    rd(4'd8, 4'd13, "R1");
    setMode(5'h13, "R1");

    // R3: supervisor pair private, user pair shared
    wr(4'd13, 32'hAAAA_0013, "R3");
    wr(4'd14, 32'hAAAA_0014, "R3");
    setMode(5'h10, "R4");
    rd(4'd13, 4'd14, "R4");
    wr(4'd13, 32'h5555_0013, "R4");
    wr(4'd9, 32'h5555_0009, "R4");
    setMode(5'h12, "R3");
    rd(4'd13, 4'd9, "R3");
    wr(4'd13, 32'h1212_0013, "R3");
    setMode(5'h1F, "R4");
    rd(4'd13, 4'd9, "R4");
    setMode(5'h13, "R3");
    rd(4'd13, 4'd14, "R3");

    // R2: fast-interrupt window over 8..14
    setMode(5'h11, "R2");
    rd(4'd9, 4'd12, "R2");
    for (int i = 8; i < 15; i++) wr(4'(i), 32'hF100_0000 | i, "R2");
    wr(4'd3, 32'h0000_C003, "R4");
    setMode(5'h10, "R2");
    rd(4'd9, 4'd3, "R2");
    rd(4'd8, 4'd14, "R2");
    setMode(5'h11, "R2");
    rd(4'd12, 4'd13, "R2");

    // R5: same-mode request keeps mapping
    setMode(5'h11, "R5");
    rd(4'd8, 4'd14, "R5");

    // R6: write with mode change lands in old view
    step(1'b1, 4'd13, 32'h0DD0_0013, 1'b1, 5'h17, 1'b0, '0, 1'b0, 4'd13, 4'd8, "R6");
    rd(4'd13, 4'd8, "R6");
    setMode(5'h11, "R6");
    rd(4'd13, 4'd14, "R6");

    // R8/R9: saved-status per mode and restore
    setMode(5'h12, "R8");
    step(1'b0, 4'd0, '0, 1'b0, 5'h0, 1'b1, 32'hC000_0013, 1'b0, 4'd0, 4'd1, "R8");
    setMode(5'h10, "R8");
    step(1'b0, 4'd0, '0, 1'b0, 5'h0, 1'b1, 32'h1234_5678, 1'b0, 4'd0, 4'd1, "R8");
    setMode(5'h12, "R9");
    step(1'b0, 4'd0, '0, 1'b0, 5'h0, 1'b0, '0, 1'b1, 4'd13, 4'd14, "R9");
    rd(4'd13, 4'd14, "R9");

    // R10: restore without a slot
    setMode(5'h10, "R10");
    step(1'b0, 4'd0, '0, 1'b0, 5'h0, 1'b0, '0, 1'b1, 4'd13, 4'd0, "R10");
    rd(4'd13, 4'd0, "R10");
    rd(4'd13, 4'd0, "R10");

    // R11: restore wins over mode request
    setMode(5'h12, "R11");
    step(1'b0, 4'd0, '0, 1'b1, 5'h1B, 1'b0, '0, 1'b1, 4'd13, 4'd14, "R11");
    rd(4'd13, 4'd14, "R11");
    setMode(5'h10, "R11");
    step(1'b0, 4'd0, '0, 1'b1, 5'h11, 1'b0, '0, 1'b1, 4'd8, 4'd13, "R11");
    rd(4'd8, 4'd13, "R11");

    // R7: random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic          rq;
      logic [DW-1:0] sd;
      rq = ($urandom % 10) == 0;
      sd = $urandom;
      if ($urandom % 2) sd[4:0] = pickMode(int'($urandom % 8));
      step(($urandom % 3) != 0, 4'($urandom), $urandom,
           ($urandom % 4) == 0, pickMode(int'($urandom % 8)),
           ($urandom % 5) == 0, sd, rq,
           4'($urandom), 4'($urandom), "R7");
    end

    doneRun = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule